// File: doc/BRIEF.md
# SPI Direct-Write Window

This block lets a bus master send SPI transmit data by writing into a memory window instead of feeding a data register one word at a time. Each chip select has its own window. A write of four bytes or a write of one byte to a window is parked in a single holding register. An engine then shifts it out in SPI mode 0 with 8-bit words. A transfer whose length is not a multiple of four ends with single-byte writes. The block only transmits. Nothing is received or read back.

Writes of zero to the release-control register (register space offset 0x20) keep the chip select asserted from one window write to the next, so a long SPI transfer can span many bus writes. A nonzero value releases the chip select after each bus write has finished shifting. The bus is back-pressured (`bus_ready` low) while the holding register is still occupied.

The engine state machine has six states. **ST_IDLE** waits for work and decides whether to release. **ST_GAP** keeps the chip select released for one half period. **ST_LEAD** is the half period after select with the clock low. **ST_CLK_HI** and **ST_CLK_LO** are the two clock phases of every bit. **ST_TAIL** is the closing low half period after the last bit.

The transitions are:
- ST_IDLE→ST_GAP when a select is held and either release mode is set or the pending entry targets a different chip select.
- ST_IDLE→ST_LEAD when an entry is pending; the entry is taken at this point.
- ST_LEAD→ST_CLK_HI and ST_CLK_LO→ST_CLK_HI after one half period.
- ST_CLK_HI→ST_CLK_LO when bits remain.
- ST_CLK_HI→ST_TAIL after the last bit of the entry.
- ST_TAIL→ST_IDLE and ST_GAP→ST_IDLE after one half period.

Top module: `spi_dwin_top`

## Requirements
- R1: After reset all `spi_cs_n` bits are 1, `spi_sclk` is 0 and `bus_ready` is 1.
- R2: A window write with `bus_byte`=0 sends the four bytes of `bus_wdata` in the order [7:0], [15:8], [23:16], [31:24]. Each byte goes out MSB first. `spi_mosi` is sampled on the rising edge of `spi_sclk` and stays stable while `spi_sclk` is high.
- R3: A window write with `bus_byte`=1 sends exactly one byte, taken from `bus_wdata[7:0]`.
- R4: A window write is one with `bus_addr[15]`=1. `bus_addr[14:12]` selects the chip select, and that chip select's `spi_cs_n` bit goes low. At most one `spi_cs_n` bit is ever low.
- R5: `bus_ready` is low while the holding register is occupied. A held-off write is accepted later, and every accepted byte is sent in acceptance order with none lost.
- R6: The release-control register is written with `bus_addr[15]`=0 and `bus_addr[14:0]`=0x20. With the value zero, which is also the reset value, the chip select stays low after a write has finished shifting.
- R7: With a nonzero release-control value, the chip select goes high after each window write has finished shifting. Once released, it stays high for at least one cycle.
- R8: When a write targets a different chip select than the one held, the held one is released before the new one goes low, and the selected index never changes while a select is asserted.
- R9: A window write to a chip select whose bit in `WIN_MASK` is clear is accepted and ignored: no `spi_sclk` edge and no change of `spi_cs_n`. With the default mask this is chip select 7.
- R10: `spi_sclk` is low whenever no chip select is asserted.
- R11: Writes to register-space offsets other than 0x20 leave the release-control setting unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Write request |
| bus_ready | output | 1 | Write accepted on a clock edge where valid and ready are both high |
| bus_addr | input | 16 | Byte address; bit 15 picks window space |
| bus_wdata | input | 32 | Write data |
| bus_byte | input | 1 | 1 = single-byte write from bits [7:0] |
| spi_sclk | output | 1 | SPI clock, idles low |
| spi_mosi | output | 1 | Serial transmit data |
| spi_cs_n | output | 8 | Active-low chip selects |

## Verification
The assertions assume the bus master holds `bus_valid`, `bus_addr`, `bus_wdata` and `bus_byte` steady until the write is accepted. They also assume the master never targets a chip select index of `NUM_CS` or more. The bench changes bus signals only on falling clock edges, drops `bus_valid` right after acceptance, and uses only chip select indices 0 to 7. The serial checks assume the receiver samples on the rising clock edge. The bench monitor detects that edge on the falling system clock and compares each completed byte, together with its chip select, against the expected queue.

// File: rtl/dw_pkg.sv
package dw_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LEAD,
        ST_CLK_HI,
        ST_CLK_LO,
        ST_TAIL,
        ST_GAP
    } dw_state_t;

    typedef struct packed {
        logic [31:0] data;
        logic        single;
    } dw_word_t;
endpackage

// File: rtl/dw_decode.sv
module dw_decode #(
    parameter int AW       = 16,
    parameter int NUM_CS   = 8,
    parameter int WIN_LSB  = 12,
    parameter int CFG_OFF  = 32'h20,
    parameter logic [NUM_CS-1:0] WIN_MASK = '1,
    localparam int CS_W    = $clog2(NUM_CS)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            bus_valid,
    input  logic [AW-1:0]   bus_addr,
    input  logic [31:0]     bus_wdata,
    input  logic            buf_full,
    output logic            bus_ready,
    output logic            push,
    output logic [CS_W-1:0] push_cs,
    output logic            cfg_release
);
    logic is_win;
    logic has_win;
    logic cfg_hit;

    assign is_win    = bus_addr[AW-1];
    assign push_cs   = bus_addr[WIN_LSB +: CS_W];
    assign has_win   = WIN_MASK[push_cs];
    assign cfg_hit   = !is_win && (bus_addr[AW-2:0] == (AW-1)'(CFG_OFF));
    assign bus_ready = !(is_win && has_win && buf_full);
    assign push      = bus_valid && is_win && has_win && !buf_full;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cfg_release <= 1'b0;
        else if (bus_valid && cfg_hit)
            cfg_release <= |bus_wdata;
    end

    // R11
    other_reg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !is_win && !cfg_hit) |=> $stable(cfg_release));
endmodule

// File: rtl/dw_hold.sv
module dw_hold
    import dw_pkg::*;
#(
    parameter int NUM_CS = 8,
    localparam int CS_W  = $clog2(NUM_CS)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            push,
    input  logic [CS_W-1:0] push_cs,
    input  dw_word_t        push_word,
    input  logic            pop,
    output logic            full,
    output logic [CS_W-1:0] ent_cs,
    output dw_word_t        ent
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            full   <= 1'b0;
            ent_cs <= '0;
            ent    <= '0;
        end else if (push) begin
            full   <= 1'b1;
            ent_cs <= push_cs;
            ent    <= push_word;
        end else if (pop) begin
            full   <= 1'b0;
        end
    end

    // R5
    no_loss_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (full && !pop) |=> (full && $stable(ent) && $stable(ent_cs)));
endmodule

// File: rtl/dw_engine.sv
module dw_engine
    import dw_pkg::*;
#(
    parameter int NUM_CS  = 8,
    parameter int CLK_DIV = 2,
    localparam int CS_W   = $clog2(NUM_CS),
    localparam int TW     = $clog2(CLK_DIV + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ent_valid,
    input  logic [CS_W-1:0] ent_cs,
    input  dw_word_t        ent,
    input  logic            cfg_release,
    output logic            pop,
    output logic            sclk,
    output logic            mosi,
    output logic            cs_on,
    output logic [CS_W-1:0] cur_cs
);
    dw_state_t   state, nxt;
    logic [TW-1:0] tmr;
    logic        half_done;
    logic [7:0]  shreg;
    logic [2:0]  bit_cnt;
    logic [23:0] word_q;
    logic [1:0]  bytes_left;
    logic        more;

    assign half_done = (tmr == TW'(CLK_DIV - 1));
    assign more      = (bit_cnt != 3'd0) || (bytes_left != 2'd0);
    assign mosi      = shreg[7];
    assign pop       = (state == ST_IDLE) && (nxt == ST_LEAD);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: begin
                if (cs_on && (cfg_release || (ent_valid && ent_cs != cur_cs)))
                    nxt = ST_GAP;
                else if (ent_valid)
                    nxt = ST_LEAD;
            end
            ST_LEAD:   if (half_done) nxt = ST_CLK_HI;
            ST_CLK_HI: if (half_done) nxt = more ? ST_CLK_LO : ST_TAIL;
            ST_CLK_LO: if (half_done) nxt = ST_CLK_HI;
            ST_TAIL:   if (half_done) nxt = ST_IDLE;
            ST_GAP:    if (half_done) nxt = ST_IDLE;
            default:   nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tmr        <= '0;
            shreg      <= '0;
            bit_cnt    <= '0;
            word_q     <= '0;
            bytes_left <= '0;
            cs_on      <= 1'b0;
            cur_cs     <= '0;
            sclk       <= 1'b0;
        end else begin
            tmr <= (state == ST_IDLE || nxt != state) ? '0 : tmr + 1'b1;
            unique case (state)
                ST_IDLE: begin
                    if (nxt == ST_GAP) begin
                        cs_on <= 1'b0;
                    end else if (nxt == ST_LEAD) begin
                        cs_on      <= 1'b1;
                        cur_cs     <= ent_cs;
                        shreg      <= ent.data[7:0];
                        word_q     <= ent.data[31:8];
                        bytes_left <= ent.single ? 2'd0 : 2'd3;
                        bit_cnt    <= 3'd7;
                    end
                end
                ST_LEAD, ST_CLK_LO: if (half_done) sclk <= 1'b1;
                ST_CLK_HI: begin
                    if (half_done) begin
                        sclk <= 1'b0;
                        if (bit_cnt != 3'd0) begin
                            shreg   <= {shreg[6:0], 1'b0};
                            bit_cnt <= bit_cnt - 3'd1;
                        end else if (bytes_left != 2'd0) begin
                            shreg      <= word_q[7:0];
                            word_q     <= {8'h00, word_q[23:8]};
                            bytes_left <= bytes_left - 2'd1;
                            bit_cnt    <= 3'd7;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    // R2
    mosi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk && $past(sclk)) |-> $stable(mosi));
    // R7
    cs_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cs_on) |=> !cs_on);
    // R8
    cs_switch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_on && $past(cs_on)) |-> $stable(cur_cs));
endmodule

// File: rtl/spi_dwin_top.sv
module spi_dwin_top
    import dw_pkg::*;
#(
    parameter int AW      = 16,
    parameter int NUM_CS  = 8,
    parameter int WIN_LSB = 12,
    parameter int CFG_OFF = 32'h20,
    parameter int CLK_DIV = 2,
    parameter logic [NUM_CS-1:0] WIN_MASK = 8'h7F,
    localparam int CS_W   = $clog2(NUM_CS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    output logic              bus_ready,
    input  logic [AW-1:0]     bus_addr,
    input  logic [31:0]       bus_wdata,
    input  logic              bus_byte,
    output logic              spi_sclk,
    output logic              spi_mosi,
    output logic [NUM_CS-1:0] spi_cs_n
);
    logic            push, pop, full, cfg_release, cs_on;
    logic [CS_W-1:0] push_cs, ent_cs, cur_cs;
    dw_word_t        push_word, ent;

    assign push_word = '{data: bus_wdata, single: bus_byte};

    dw_decode #(.AW(AW), .NUM_CS(NUM_CS), .WIN_LSB(WIN_LSB),
                .CFG_OFF(CFG_OFF), .WIN_MASK(WIN_MASK)) u_decode (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .buf_full(full), .bus_ready(bus_ready),
        .push(push), .push_cs(push_cs), .cfg_release(cfg_release));

    dw_hold #(.NUM_CS(NUM_CS)) u_hold (
        .clk(clk), .rst_n(rst_n), .push(push), .push_cs(push_cs),
        .push_word(push_word), .pop(pop), .full(full), .ent_cs(ent_cs),
        .ent(ent));

    dw_engine #(.NUM_CS(NUM_CS), .CLK_DIV(CLK_DIV)) u_engine (
        .clk(clk), .rst_n(rst_n), .ent_valid(full), .ent_cs(ent_cs),
        .ent(ent), .cfg_release(cfg_release), .pop(pop), .sclk(spi_sclk),
        .mosi(spi_mosi), .cs_on(cs_on), .cur_cs(cur_cs));

    for (genvar i = 0; i < NUM_CS; i++) begin : g_cs
        assign spi_cs_n[i] = !(cs_on && cur_cs == CS_W'(i));
    end

    // R4
    cs_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~spi_cs_n));
    // R10
    sclk_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        spi_sclk |-> !(&spi_cs_n));
endmodule

// File: tb/spi_dwin_top_bench.sv
module spi_dwin_top_bench;
    logic        clk = 0;
    logic        rst_n = 0;
    logic        bus_valid = 0;
    logic        bus_ready;
    logic [15:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        bus_byte = 0;
    logic        spi_sclk, spi_mosi;
    logic [7:0]  spi_cs_n;

    int total = 0, bad = 0, stalls = 0, edges = 0, multi_sel = 0, cyc = 0;
    bit done = 0;
    logic [10:0] expq[$];

    always #2.5 clk = ~clk;

    spi_dwin_top u_spi_dwin_top (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_ready(bus_ready),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_byte(bus_byte),
        .spi_sclk(spi_sclk), .spi_mosi(spi_mosi), .spi_cs_n(spi_cs_n));

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic int sel_idx(input logic [7:0] n);
        for (int i = 0; i < 8; i++) if (!n[i]) return i;
        return 15;
    endfunction

    // monitor: rebuild bytes on rising sclk, compare with expected queue (R2 R3 R4 R5)
    logic       sclk_prev = 0;
    logic [7:0] rx = 0;
    int         rx_bits = 0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (!$onehot0(~spi_cs_n)) multi_sel++;
            if (spi_sclk && !sclk_prev) begin
                edges++;
                rx = {rx[6:0], spi_mosi};
                rx_bits++;
                if (rx_bits == 8) begin
                    logic [10:0] got, want;
                    rx_bits = 0;
                    got = {3'(sel_idx(spi_cs_n)), rx};
                    if (expq.size() == 0) chk(0, "R2 unexpected byte", got, 0);
                    else begin
                        want = expq.pop_front();
                        chk(got == want, "R2 R4 byte/cs", got, want);
                    end
                end
            end
            sclk_prev = spi_sclk;
        end
    end

    task automatic bus_wr(input logic [15:0] a, input logic [31:0] d, input logic single);
        @(negedge clk);
        bus_valid = 1; bus_addr = a; bus_wdata = d; bus_byte = single;
        #1;
        while (!bus_ready) begin stalls++; @(negedge clk); end
        if (a[15] && a[14:12] != 3'd7) begin
            expq.push_back({a[14:12], d[7:0]});
            if (!single) begin
                expq.push_back({a[14:12], d[15:8]});
                expq.push_back({a[14:12], d[23:16]});
                expq.push_back({a[14:12], d[31:24]});
            end
        end
        @(negedge clk);
        bus_valid = 0;
    endtask

    function automatic logic [15:0] win(input int cs);
        return 16'h8000 | 16'(cs << 12);
    endfunction

    task automatic quiet();
        int q = 0;
        while (q < 60) begin
            @(negedge clk);
            if (bus_ready && !spi_sclk) q++; else q = 0;
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            done = 1;
            chk(0, "watchdog", cyc, 150000);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int e0;
        logic [7:0] cs0;
        repeat (3) @(negedge clk);
        // R1
        chk(spi_cs_n == 8'hFF, "R1 cs_n", spi_cs_n, 8'hFF);
        chk(spi_sclk == 0, "R1 sclk", spi_sclk, 0);
        chk(bus_ready == 1, "R1 ready", bus_ready, 1);
        rst_n = 1;
        // R2 R6: word to cs0 in hold mode
        bus_wr(win(0), 32'h44332211, 0);
        quiet();
        chk(spi_cs_n == 8'hFE, "R6 cs held", spi_cs_n, 8'hFE);
        // R3
        bus_wr(win(0), 32'hFFFF_FFA5, 1);
        quiet();
        chk(spi_cs_n == 8'hFE, "R3 R6 cs held after byte", spi_cs_n, 8'hFE);
        // R8 R5: switch to cs2 with back-to-back writes
        bus_wr(win(2), 32'hDEADBEEF, 0);
        bus_wr(win(2), 32'h01020304, 0);
        bus_wr(win(2), 32'h0000007E, 1);
        chk(stalls > 0, "R5 back-pressure", stalls, 1);
        quiet();
        chk(spi_cs_n == 8'hFB, "R8 cs2 selected", spi_cs_n, 8'hFB);
        // R7: release mode
        bus_wr(16'h0020, 32'h1, 0);
        quiet();
        chk(spi_cs_n == 8'hFF, "R7 release at idle", spi_cs_n, 8'hFF);
        bus_wr(win(1), 32'hCAFEF00D, 0);
        quiet();
        chk(spi_cs_n == 8'hFF, "R7 released after write", spi_cs_n, 8'hFF);
        // R9: cs7 has no window
        e0 = edges;
        bus_wr(win(7), 32'h12345678, 0);
        quiet();
        chk(edges == e0, "R9 no sclk edges", edges, e0);
        chk(spi_cs_n == 8'hFF, "R9 cs unchanged", spi_cs_n, 8'hFF);
        // R11: other offset with zero keeps release mode
        bus_wr(16'h0024, 32'h0, 0);
        bus_wr(win(3), 32'h5A5A0F0F, 0);
        quiet();
        chk(spi_cs_n == 8'hFF, "R11 release kept", spi_cs_n, 8'hFF);
        // R6 back to hold, then R11 nonzero to other offset
        bus_wr(16'h0020, 32'h0, 0);
        bus_wr(win(3), 32'h00000081, 1);
        quiet();
        cs0 = spi_cs_n;
        chk(cs0 == 8'hF7, "R6 hold cs3", cs0, 8'hF7);
        bus_wr(16'h0024, 32'h7, 0);
        quiet();
        chk(spi_cs_n == 8'hF7, "R11 hold kept", spi_cs_n, 8'hF7);
        // R5 R8 R10 end checks
        chk(expq.size() == 0, "R5 all bytes sent", expq.size(), 0);
        chk(multi_sel == 0, "R8 single select", multi_sel, 0);
        chk(rx_bits == 0, "R10 whole bytes only", rx_bits, 0);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule